// File: doc/BRIEF.md
# Four-Way Page Translation Lookup with Ranked Protection Faults

This block holds a set-associative translation buffer of 16 indices by 4 ways for 8 KiB pages and answers one lookup per request. The requester presents a 19-bit virtual page number, the kind of access, a user-mode flag, the current 8-bit process ID and four check-enable bits. One cycle later the block reports either a clean hit, with the physical frame and the granted read/write/execute rights, or a fault, with a vector number. Misses and protection faults are told apart by the offset added to a vector base. The base is 4 for instruction fetches and 8 for data accesses.

On every fault the block captures the context by itself. A selection register receives the index and the way that software should rewrite. A cause register receives the page number, the access kind and the process ID. On a miss the way comes from a 16-bit linear feedback shift register, and that register advances only when a fault occurs. Software loads entries through a one-cycle write port that addresses a single index and way.

The control is a two-state machine. `ST_IDLE` means no result is pending. `ST_RESP` means the response outputs carry a result. The transition `req_start` (a request is present) goes to `ST_RESP` from either state, so back-to-back requests keep the machine in `ST_RESP`. The transition `req_none` (no request) goes to `ST_IDLE` from either state.

Top module: `vpage_tlb`

## Requirements
- R1: After reset `rsp_valid` is 0, `sel_reg` and `cause_reg` are 0, every stored entry is all zero and the shift register holds 0xCCCC.
- R2: A lookup reads index `req_vpage[3:0]`. A way hits when its stored tag equals `req_vpage` and either its global flag (flag bit 4) is set or its stored process ID equals `cur_pid`.
- R3: When several ways hit, the lowest-numbered way supplies the frame and the flags.
- R4: A lookup with no hitting way faults with vector base+0. The base is 4 when `req_kind` is 2 (execute) and 8 for any other kind. The reported frame and rights are 0.
- R5: After a hit, the checks are ranked in this order: kernel entry (flag bit 2) with `req_user` gives base+2; write (kind 1) to an entry without the writable flag (bit 1) gives base+3; execute (kind 2) of an entry without the executable flag (bit 0) gives base+3; an entry without the valid flag (bit 3) gives base+1. Each check is active only when its enable is set: `cfg_chk[3]` write, `cfg_chk[2]` kernel, `cfg_chk[1]` execute, `cfg_chk[0]` valid. On a protection fault the frame of the hitting entry is still reported and the rights are 0.
- R6: A clean hit gives `rsp_fault`=0, vector 0, and the frame of the hitting entry. `rsp_perm` bit 0 (read) is always 1, bit 1 (write) copies the writable flag and bit 2 (execute) copies the executable flag.
- R7: On a fault, `sel_reg` becomes zero except for bits 3:0 = index and bits 5:4 = way. The way is the hitting way for a protection fault and the low 2 bits of the shift register before the fault for a miss. Without a fault, `sel_reg` keeps its value.
- R8: On a fault, `cause_reg` becomes {page number in 31:13, zeros in 12:10, access code in 9:8, `cur_pid` in 7:0}. The access code is 0 for read, 1 for write, 2 for execute, and kind 3 is reported as 0. Without a fault, `cause_reg` keeps its value.
- R9: On each fault the shift register moves right by one bit, and the parity of (state AND 0x8805) enters bit 15. It does not move on a clean hit or when idle.
- R10: `rsp_valid` is 1 exactly in the cycle after a cycle with `req` high. An entry written through the write port at one clock edge is seen by lookups presented after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write one entry at the next edge |
| wr_idx | input | 4 | Index of the entry to write |
| wr_way | input | 2 | Way of the entry to write |
| wr_tag | input | 19 | Virtual page tag to store |
| wr_pid | input | 8 | Process ID to store |
| wr_frame | input | 19 | Physical frame number to store |
| wr_flags | input | 5 | Flags: 4 global, 3 valid, 2 kernel, 1 writable, 0 executable |
| req | input | 1 | Lookup request |
| req_vpage | input | 19 | Virtual page number (address bits 31:13) |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 treated as read |
| req_user | input | 1 | Access made in user mode |
| cur_pid | input | 8 | Current process ID |
| cfg_chk | input | 4 | Check enables: 3 write, 2 kernel, 1 execute, 0 valid |
| rsp_valid | output | 1 | Response outputs carry a result |
| rsp_fault | output | 1 | The lookup faulted |
| rsp_vector | output | 4 | Fault vector number, 0 on a clean hit |
| rsp_frame | output | 19 | Physical frame number |
| rsp_perm | output | 3 | Granted rights: 0 read, 1 write, 2 execute |
| sel_reg | output | 32 | Way/index selection captured on a fault |
| cause_reg | output | 32 | Fault cause captured on a fault |

## Verification
Every lookup result is registered once. Fault, vector, frame, rights, the selection and cause registers and the shift-register advance therefore all belong to the clock edge that follows the request cycle. The bench drives each request on a falling edge and compares every output with its model on the next falling edge, half a period after the edge that produced it. During the idle cycles between requests it checks that `rsp_valid` is low and that both capture registers are unchanged. Writes through the write port are done in a separate cycle before any lookup that depends on them, so each entry is already in place when the lookup reads it.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VPN_W = 19;
    localparam int PID_W = 8;
    localparam int FLG_W = 5;
    localparam int LFSR_W = 16;

    localparam int FL_GLB = 4;
    localparam int FL_VAL = 3;
    localparam int FL_KRN = 2;
    localparam int FL_WR  = 1;
    localparam int FL_EX  = 0;

    localparam int EN_WR  = 3;
    localparam int EN_KRN = 2;
    localparam int EN_EX  = 1;
    localparam int EN_VAL = 0;

    localparam logic [3:0] VEC_BASE_INSN = 4'd4;
    localparam logic [3:0] VEC_BASE_DATA = 4'd8;
    localparam logic [3:0] OFS_REFILL  = 4'd0;
    localparam logic [3:0] OFS_INVALID = 4'd1;
    localparam logic [3:0] OFS_ACCESS  = 4'd2;
    localparam logic [3:0] OFS_PROT    = 4'd3;

    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hCCCC;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [VPN_W-1:0] tag;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] frame;
        logic [FLG_W-1:0] flags;
    } tlb_entry_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {^(s & LFSR_TAPS), s[LFSR_W-1:1]};
    endfunction

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter int NIDX  = 16,
    parameter int NWAYS = 4,
    localparam int IDX_W = $clog2(NIDX),
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WAY_W-1:0]              wr_way,
    input  tlb_entry_t                    wr_ent,
    input  logic [IDX_W-1:0]              rd_idx,
    output tlb_entry_t [NWAYS-1:0]        rd_ent
);

    tlb_entry_t mem_q [NIDX][NWAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NIDX; i++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    mem_q[i][w] <= '0;
                end
            end
        end else if (wr_en) begin
            mem_q[wr_idx][wr_way] <= wr_ent;
        end
    end

    for (genvar g = 0; g < NWAYS; g++) begin : g_rd
        assign rd_ent[g] = mem_q[rd_idx][g];
    end

endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
#(
    parameter int NWAYS = 4,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  tlb_entry_t [NWAYS-1:0] ways,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [PID_W-1:0]       pid,
    input  acc_kind_e              kind,
    input  logic                   user,
    input  logic [3:0]             chk_en,
    output logic                   hit,
    output logic [WAY_W-1:0]       hit_way,
    output logic                   fault,
    output logic [3:0]             vector,
    output logic [VPN_W-1:0]       frame,
    output logic [2:0]             perm
);

    logic [NWAYS-1:0] hit_vec;
    logic [FLG_W-1:0] fl;
    logic [3:0]       base;

    for (genvar g = 0; g < NWAYS; g++) begin : g_cmp
        assign hit_vec[g] = (ways[g].tag == vpn) &&
                            (ways[g].flags[FL_GLB] || (ways[g].pid == pid));
    end

    always_comb begin
        hit_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit  = |hit_vec;
    assign fl   = ways[hit_way].flags;
    assign base = (kind == ACC_EXEC) ? VEC_BASE_INSN : VEC_BASE_DATA;

    always_comb begin
        fault  = 1'b0;
        vector = '0;
        frame  = '0;
        perm   = '0;
        if (!hit) begin
            fault  = 1'b1;
            vector = base + OFS_REFILL;
        end else begin
            frame = ways[hit_way].frame;
            if (chk_en[EN_KRN] && fl[FL_KRN] && user) begin
                fault  = 1'b1;
                vector = base + OFS_ACCESS;
            end else if (kind == ACC_WRITE && chk_en[EN_WR] && !fl[FL_WR]) begin
                fault  = 1'b1;
                vector = base + OFS_PROT;
            end else if (kind == ACC_EXEC && chk_en[EN_EX] && !fl[FL_EX]) begin
                fault  = 1'b1;
                vector = base + OFS_PROT;
            end else if (chk_en[EN_VAL] && !fl[FL_VAL]) begin
                fault  = 1'b1;
                vector = base + OFS_INVALID;
            end else begin
                perm = {fl[FL_EX], fl[FL_WR], 1'b1};
            end
        end
    end

endmodule

// File: rtl/tlbx_lfsr.sv
module tlbx_lfsr
    import tlbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [LFSR_W-1:0] state
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state <= LFSR_SEED;
        else if (advance) state <= lfsr_step(state);
    end

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
    import tlbx_pkg::*;
#(
    parameter int NIDX  = 16,
    parameter int NWAYS = 4,
    localparam int IDX_W = $clog2(NIDX),
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WAY_W-1:0]   wr_way,
    input  logic [VPN_W-1:0]   wr_tag,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [VPN_W-1:0]   wr_frame,
    input  logic [FLG_W-1:0]   wr_flags,
    input  logic               req,
    input  logic [VPN_W-1:0]   req_vpage,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic [PID_W-1:0]   cur_pid,
    input  logic [3:0]         cfg_chk,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [3:0]         rsp_vector,
    output logic [VPN_W-1:0]   rsp_frame,
    output logic [2:0]         rsp_perm,
    output logic [31:0]        sel_reg,
    output logic [31:0]        cause_reg
);

    typedef enum logic {ST_IDLE, ST_RESP} st_e;

    st_e                    st_q, st_d;
    tlb_entry_t [NWAYS-1:0] ways;
    tlb_entry_t             wr_ent;
    logic [IDX_W-1:0]       idx;
    acc_kind_e              kind;
    logic                   m_hit, m_fault;
    logic [WAY_W-1:0]       m_way, sel_way;
    logic [3:0]             m_vec;
    logic [VPN_W-1:0]       m_frame;
    logic [2:0]             m_perm;
    logic [LFSR_W-1:0]      lfsr_q;
    logic [1:0]             acc_code;
    logic [31:0]            sel_d, cause_d;

    assign idx    = req_vpage[IDX_W-1:0];
    assign kind   = acc_kind_e'(req_kind);
    assign wr_ent = '{tag: wr_tag, pid: wr_pid, frame: wr_frame, flags: wr_flags};

    tlbx_store #(.NIDX(NIDX), .NWAYS(NWAYS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_way(wr_way), .wr_ent(wr_ent), .rd_idx(idx), .rd_ent(ways)
    );

    tlbx_match #(.NWAYS(NWAYS)) u_match (
        .ways(ways), .vpn(req_vpage), .pid(cur_pid), .kind(kind),
        .user(req_user), .chk_en(cfg_chk), .hit(m_hit), .hit_way(m_way),
        .fault(m_fault), .vector(m_vec), .frame(m_frame), .perm(m_perm)
    );

    tlbx_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .advance(req && m_fault), .state(lfsr_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: req_start / req_none
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = req ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = req ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign sel_way  = m_hit ? m_way : lfsr_q[WAY_W-1:0];
    assign acc_code = (kind == ACC_RSVD) ? 2'd0 : req_kind;

    always_comb begin
        sel_d = '0;
        sel_d[IDX_W-1:0]      = idx;
        sel_d[IDX_W +: WAY_W] = sel_way;
        cause_d = {req_vpage, 3'b000, acc_code, cur_pid};
    end

    // outputs
    assign rsp_valid = (st_q == ST_RESP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_fault  <= 1'b0;
            rsp_vector <= '0;
            rsp_frame  <= '0;
            rsp_perm   <= '0;
            sel_reg    <= '0;
            cause_reg  <= '0;
        end else if (req) begin
            rsp_fault  <= m_fault;
            rsp_vector <= m_vec;
            rsp_frame  <= m_frame;
            rsp_perm   <= m_perm;
            if (m_fault) begin
                sel_reg   <= sel_d;
                cause_reg <= cause_d;
            end
        end
    end

    // R10: response exactly one cycle after a request
    a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    a_r10_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);
    // R4 / R5: a fault always carries a non-zero vector, and no rights
    a_r4_fault_has_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_vector != 4'd0));
    a_r6_no_perm_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_perm == 3'd0));
    a_r6_read_on_clean_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_perm[0] && rsp_vector == 4'd0));
    // R7 / R8: capture registers hold when no fault is reported
    a_r7_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> $stable(sel_reg));
    a_r8_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> $stable(cause_reg));
    a_r7_sel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel_reg[31:IDX_W+WAY_W] == '0);
    // R9: shift register holds without a fault and never reaches zero
    a_r9_lfsr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> $stable(lfsr_q));
    a_r9_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: tb/sim_vpage_tlb.sv
module sim_vpage_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_way = '0;
    logic [18:0] wr_tag = '0;
    logic [7:0]  wr_pid = '0;
    logic [18:0] wr_frame = '0;
    logic [4:0]  wr_flags = '0;
    logic        req = 1'b0;
    logic [18:0] req_vpage = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [7:0]  cur_pid = '0;
    logic [3:0]  cfg_chk = '0;
    logic        rsp_valid, rsp_fault;
    logic [3:0]  rsp_vector;
    logic [18:0] rsp_frame;
    logic [2:0]  rsp_perm;
    logic [31:0] sel_reg, cause_reg;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vpage_tlb u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way),
        .wr_tag(wr_tag), .wr_pid(wr_pid), .wr_frame(wr_frame), .wr_flags(wr_flags),
        .req(req), .req_vpage(req_vpage), .req_kind(req_kind), .req_user(req_user),
        .cur_pid(cur_pid), .cfg_chk(cfg_chk), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_vector(rsp_vector), .rsp_frame(rsp_frame),
        .rsp_perm(rsp_perm), .sel_reg(sel_reg), .cause_reg(cause_reg)
    );

    // behavioural reference state
    int unsigned m_tag [16][4];
    int unsigned m_pid [16][4];
    int unsigned m_frm [16][4];
    int unsigned m_flg [16][4];
    int unsigned m_lfsr = 32'hCCCC;
    int unsigned m_sel = 0;
    int unsigned m_cause = 0;

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic wr_entry(input int i, input int w, input int unsigned tg,
                            input int unsigned pd, input int unsigned fr,
                            input int unsigned fl);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(i); wr_way = 2'(w);
        wr_tag = 19'(tg); wr_pid = 8'(pd); wr_frame = 19'(fr); wr_flags = 5'(fl);
        m_tag[i][w] = tg; m_pid[i][w] = pd; m_frm[i][w] = fr; m_flg[i][w] = fl;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input int unsigned vpn, input int kind, input bit user,
                          input int unsigned pid, input int unsigned cfg,
                          input string tag);
        int unsigned idx, fl, base, e_vec, e_frm, e_perm, way, f, code;
        int hw;
        bit e_fault;
        idx = vpn % 16;
        hw = -1;
        for (int w = 3; w >= 0; w--) begin
            if (m_tag[idx][w] == vpn && (((m_flg[idx][w] >> 4) & 1) == 1 || m_pid[idx][w] == pid))
                hw = w;
        end
        base = (kind == 2) ? 4 : 8;
        e_fault = 1'b0; e_vec = 0; e_frm = 0; e_perm = 0;
        if (hw < 0) begin
            e_fault = 1'b1; e_vec = base; way = m_lfsr % 4;
        end else begin
            fl = m_flg[idx][hw];
            e_frm = m_frm[idx][hw];
            way = hw;
            if ((cfg & 4) != 0 && (fl & 4) != 0 && user) begin
                e_fault = 1'b1; e_vec = base + 2;
            end else if (kind == 1 && (cfg & 8) != 0 && (fl & 2) == 0) begin
                e_fault = 1'b1; e_vec = base + 3;
            end else if (kind == 2 && (cfg & 2) != 0 && (fl & 1) == 0) begin
                e_fault = 1'b1; e_vec = base + 3;
            end else if ((cfg & 1) != 0 && (fl & 8) == 0) begin
                e_fault = 1'b1; e_vec = base + 1;
            end else begin
                e_perm = 1 + (((fl >> 1) & 1) * 2) + ((fl & 1) * 4);
            end
        end
        if (e_fault) begin
            code = (kind == 3) ? 0 : kind;
            m_sel = idx + way * 16;
            m_cause = (vpn << 13) | (code << 8) | pid;
            f = 0;
            for (int b = 0; b < 16; b++) f ^= ((m_lfsr & 32'h8805) >> b) & 1;
            m_lfsr = (m_lfsr >> 1) | (f << 15);
        end
        @(negedge clk);
        req = 1'b1; req_vpage = 19'(vpn); req_kind = 2'(kind);
        req_user = user; cur_pid = 8'(pid); cfg_chk = 4'(cfg);
        @(negedge clk);
        req = 1'b0;
        chk("R10", "rsp_valid one cycle after req", rsp_valid, 1);
        chk(tag, "rsp_fault", rsp_fault, e_fault);
        chk(tag, "rsp_vector", rsp_vector, e_vec);
        chk(tag, "rsp_frame", rsp_frame, e_frm);
        chk(tag, "rsp_perm", rsp_perm, e_perm);
        chk("R7", "sel_reg", sel_reg, m_sel);
        chk("R8", "cause_reg", cause_reg, m_cause);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R10", "rsp_valid when idle", rsp_valid, 0);
        chk("R7", "sel_reg idle", sel_reg, m_sel);
        chk("R8", "cause_reg idle", cause_reg, m_cause);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++)
            for (int w = 0; w < 4; w++) begin
                m_tag[i][w] = 0; m_pid[i][w] = 0; m_frm[i][w] = 0; m_flg[i][w] = 0;
            end
        repeat (3) @(negedge clk);
        chk("R1", "rsp_valid in reset", rsp_valid, 0);
        chk("R1", "sel_reg in reset", sel_reg, 0);
        chk("R1", "cause_reg in reset", cause_reg, 0);
        rst_n = 1'b1;
        idle_check();

        // first miss after reset: way from seed 0xCCCC (low bits 0)
        lookup(32'h4A5B2, 0, 1'b0, 3, 0, "R4");
        idle_check();

        // R2: process-ID and global matching
        wr_entry(3, 0, 32'h00123, 5, 32'h007AB, 5'b01011);
        lookup(32'h00123, 0, 1'b0, 5, 0, "R6");
        lookup(32'h00123, 0, 1'b0, 6, 0, "R2");
        wr_entry(3, 2, 32'h00123, 6, 32'h00111, 5'b11000);
        lookup(32'h00123, 1, 1'b0, 6, 4'hF, "R2");
        lookup(32'h00123, 0, 1'b0, 77, 0, "R2");
        lookup(32'h00133, 0, 1'b0, 6, 0, "R2");

        // R3: lowest hitting way wins
        lookup(32'h00123, 0, 1'b0, 5, 0, "R3");
        wr_entry(3, 1, 32'h00123, 9, 32'h00222, 5'b11010);
        lookup(32'h00123, 2, 1'b0, 9, 0, "R3");
        lookup(32'h00123, 2, 1'b0, 5, 4'hF, "R6");
        idle_check();

        // R5: ranked protection checks on a kernel-only entry
        wr_entry(7, 3, 32'h04567, 1, 32'h00333, 5'b00100);
        lookup(32'h04567, 1, 1'b1, 1, 4'hF, "R5");
        lookup(32'h04567, 1, 1'b0, 1, 4'hF, "R5");
        lookup(32'h04567, 1, 1'b1, 1, 4'hB, "R5");
        lookup(32'h04567, 0, 1'b0, 1, 4'hF, "R5");
        lookup(32'h04567, 2, 1'b0, 1, 4'hF, "R5");
        lookup(32'h04567, 2, 1'b0, 1, 4'h1, "R5");
        lookup(32'h04567, 1, 1'b1, 1, 4'h0, "R5");
        lookup(32'h04567, 2, 1'b1, 1, 4'h8, "R6");
        idle_check();

        // R4 / R9: sequence of misses walks the shift register
        lookup(32'h7FFF0, 2, 1'b0, 3, 4'hF, "R4");
        for (int n = 0; n < 10; n++) begin
            lookup(32'h10000 + n * 32'h1111, n % 4, n[0], n * 17, 0, "R9");
        end
        idle_check();
        // R9: clean hit between misses leaves shift register unchanged
        lookup(32'h00123, 0, 1'b0, 5, 4'hF, "R9");
        lookup(32'h3ABCD, 3, 1'b0, 200, 0, "R9");
        lookup(32'h3ABCE, 1, 1'b0, 201, 0, "R9");
        idle_check();

        summary();
        $finish;
    end

endmodule